// File: doc/BRIEF.md
# Quadrature Sine/Cosine Serial DAC Sequencer

This block is a free-running master that keeps a four-channel serial DAC fed with a quadrature waveform. Channels A and B carry a sine and its inverse, so together they form a differential sine pair. Channels C and D carry a cosine and its inverse, forming the matching differential cosine pair. A two-stage programmable timer fixes the sample rate.

On every timer tick the sequencer does the following, in order:
1. It pulses the load strobe low, which releases the samples that were sent during the previous tick.
2. It drops chip select.
3. It shifts out four 16-bit frames, one per channel. Each frame has its own frame-sync window and its own burst of serial clocks.
4. It raises chip select and advances a shared rolling pointer.

The sample table is computed from a nine-point quarter wave using the symmetry of the sine. All four channels read that table at fixed phase offsets from the one pointer.

There is no streaming interface. The timer configuration inputs are plain levels, and all DAC-side pins are plain outputs.

Top module: `quad_wave_seq`

## Requirements
- R1: While rst_n is low, and after its release until the first tick, chip select, frame sync, load strobe and serial clock are all high, and overrun_o is low.
- R2: Ticks recur every (1+period_i)·(1+prescale_i) system clocks without reprogramming. When no tick is skipped, the load-strobe falling edges are spaced by exactly that number of cycles.
- R3: Each accepted tick first drives dac_ldac_n_o low for exactly SCLK_HALF cycles, while chip select is still high.
- R4: Every chip-select low window contains exactly four frames.
- R5: Each frame is 16 bits, most significant bit first, and each bit is taken on a falling edge of dac_sclk_o while frame sync and chip select are low. The frame layout is: bits 15:14 are the channel address (A=0, B=1, C=2, D=3), bit 13 is power-down (always 0), bit 12 is fast speed (always 1), and bits 11:0 are the sample. Frames are sent in the order A, B, C, D.
- R6: With pointer p, the samples are A=S(p), B=S(p+16), C=S(p+8) and D=S(p+24), all taken modulo 32. The pointer is 0 after reset, increases by one after each completed sequence, and wraps from 31 to 0.
- R7: The sample function S(k) for k in 0..31 is defined as follows. Let q = k mod 16 and j = q when q≤8, otherwise j = 16−q. Let v be entry j of the quarter list 0x800, 0x97C, 0xAE9, 0xC3A, 0xD61, 0xE53, 0xF07, 0xF76, 0xF9C. Then S(k) = v for k<16, and S(k) = 0x1000−v otherwise.
- R8: The data line never changes at a falling serial-clock edge. It changes only while the serial clock rises or stays high.
- R9: Frame sync rises only after the 16th falling edge and a further rising edge, so the serial clock is high when it rises. It then stays high for at least 2·SCLK_HALF cycles before the next frame starts.
- R10: A tick that arrives while a sequence is running pulses overrun_o for one cycle. That tick starts no sequence and does not advance the pointer.
- R11: Frame sync is high whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PRD_W | Main timer reload value (count+1 stages) |
| prescale_i | input | PRE_W | Prescaler reload value (count+1 clocks per stage) |
| dac_sclk_o | output | 1 | Serial clock; idles high |
| dac_din_o | output | 1 | Serial data, MSB first |
| dac_fs_o | output | 1 | Frame sync, low for each frame |
| dac_cs_n_o | output | 1 | Chip select, active low |
| dac_ldac_n_o | output | 1 | Load strobe, active low |
| overrun_o | output | 1 | One-cycle pulse when a tick is skipped |

## Verification
The assertions assume the following about the inputs:
- period_i and prescale_i stay constant outside reset, so the tick spacing they guard is fixed for a whole run.
- At least one of period_i and prescale_i is non-zero.

The stimulus changes the timer configuration only while rst_n is held low. It first runs a period longer than one full four-frame sequence, for more than 32 sequences so that the pointer wraps. It then switches to a period shorter than a sequence, which forces every second tick to overrun. A DAC model in the bench captures bits on serial-clock falling edges and compares each frame against a queue of words built from R5 to R7.

// File: rtl/qws_pkg.sv
package qws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_SEND,
    ST_WAIT,
    ST_CLOSE
  } seq_state_t;

  // quarter-wave points, midscale-centred 12-bit
  function automatic logic [11:0] quarter_pt(input logic [3:0] j);
    case (j)
      4'd0:    quarter_pt = 12'h800;
      4'd1:    quarter_pt = 12'h97C;
      4'd2:    quarter_pt = 12'hAE9;
      4'd3:    quarter_pt = 12'hC3A;
      4'd4:    quarter_pt = 12'hD61;
      4'd5:    quarter_pt = 12'hE53;
      4'd6:    quarter_pt = 12'hF07;
      4'd7:    quarter_pt = 12'hF76;
      default: quarter_pt = 12'hF9C;
    endcase
  endfunction

  // phase offset in table steps for each channel address
  function automatic logic [4:0] lane_offset(input logic [1:0] ch);
    case (ch)
      2'd0:    lane_offset = 5'd0;
      2'd1:    lane_offset = 5'd16;
      2'd2:    lane_offset = 5'd8;
      default: lane_offset = 5'd24;
    endcase
  endfunction

  // address, power-down=0, fast=1, sample
  function automatic logic [15:0] frame_word(input logic [1:0] ch, input logic [11:0] s);
    frame_word = {ch, 1'b0, 1'b1, s};
  endfunction

endpackage

// File: rtl/qws_tick_timer.sv
module qws_tick_timer #(
  parameter int PRD_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRD_W-1:0] period_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRD_W-1:0] main_cnt;
  logic pre_wrap, main_wrap;

  assign pre_wrap  = (pre_cnt >= prescale_i);
  assign main_wrap = (main_cnt >= period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      main_cnt <= '0;
      tick_o   <= 1'b0;
    end else begin
      tick_o <= pre_wrap && main_wrap;
      if (pre_wrap) begin
        pre_cnt <= '0;
        if (main_wrap) main_cnt <= '0;
        else           main_cnt <= main_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (period_i != '0 || prescale_i != '0)) |=> !tick_o)
    else $error("tick_gap_chk");

endmodule

// File: rtl/qws_wave_rom.sv
module qws_wave_rom (
  input  logic [4:0]  index_i,
  output logic [11:0] sample_o
);
  import qws_pkg::*;
  logic [3:0]  q;
  logic [3:0]  j;
  logic [11:0] v;

  always_comb begin
    q = index_i[3:0];
    j = (q <= 4'd8) ? q : 4'(5'd16 - {1'b0, q});
    v = quarter_pt(j);
    sample_o = index_i[4] ? 12'(13'h1000 - {1'b0, v}) : v;
  end
endmodule

// File: rtl/qws_frame_shifter.sv
module qws_frame_shifter #(
  parameter int WORD_W    = 16,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              done_o,
  output logic              sclk_o,
  output logic              din_o,
  output logic              fs_o
);
  localparam int STEPS  = 2 * WORD_W + 3;
  localparam int STEP_W = $clog2(STEPS);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int HC_W   = $clog2(SCLK_HALF) + 1;
  localparam int BITS2  = 2 * WORD_W;

  logic              busy;
  logic [STEP_W-1:0] step;
  logic [HC_W-1:0]   hcnt;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  bit_idx;
  logic              in_bits;

  assign in_bits = busy && (step < STEP_W'(BITS2));
  assign bit_idx = IDX_W'(WORD_W - 1) - step[IDX_W:1];
  assign sclk_o  = !(in_bits && step[0]);
  assign din_o   = in_bits ? word_q[bit_idx] : 1'b0;
  assign fs_o    = !(busy && (step <= STEP_W'(BITS2)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      hcnt   <= '0;
      word_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy   <= 1'b1;
          step   <= '0;
          hcnt   <= '0;
          word_q <= word_i;
        end
      end else if (hcnt == HC_W'(SCLK_HALF - 1)) begin
        hcnt <= '0;
        if (step == STEP_W'(STEPS - 1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R8
  din_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> $stable(din_o))
    else $error("din_stable_chk");

  // R9
  fs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_o) |-> sclk_o)
    else $error("fs_rise_chk");

endmodule

// File: rtl/quad_wave_seq.sv
module quad_wave_seq #(
  parameter int PRD_W     = 16,
  parameter int PRE_W     = 4,
  parameter int SCLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRD_W-1:0] period_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             dac_sclk_o,
  output logic             dac_din_o,
  output logic             dac_fs_o,
  output logic             dac_cs_n_o,
  output logic             dac_ldac_n_o,
  output logic             overrun_o
);
  import qws_pkg::*;
  localparam int WORD_W = 16;
  localparam int WC_W   = $clog2(SCLK_HALF) + 1;

  seq_state_t      state;
  logic [WC_W-1:0] wcnt;
  logic [1:0]      ch;
  logic [4:0]      ptr;
  logic            tick, shift_done, shift_start;
  logic [11:0]     sample;
  logic            wait_end;

  qws_tick_timer #(.PRD_W(PRD_W), .PRE_W(PRE_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .prescale_i(prescale_i), .tick_o(tick));

  qws_wave_rom rom_i (.index_i(ptr + lane_offset(ch)), .sample_o(sample));

  assign shift_start = (state == ST_SEND);

  qws_frame_shifter #(.WORD_W(WORD_W), .SCLK_HALF(SCLK_HALF)) shift_i (
    .clk(clk), .rst_n(rst_n), .start_i(shift_start),
    .word_i(frame_word(ch, sample)), .done_o(shift_done),
    .sclk_o(dac_sclk_o), .din_o(dac_din_o), .fs_o(dac_fs_o));

  assign wait_end     = (wcnt == WC_W'(SCLK_HALF - 1));
  assign dac_ldac_n_o = (state != ST_LOAD);
  assign dac_cs_n_o   = !(state == ST_SETUP || state == ST_SEND || state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wcnt      <= '0;
      ch        <= '0;
      ptr       <= '0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= tick && (state != ST_IDLE);
      case (state)
        ST_IDLE: if (tick) begin state <= ST_LOAD; wcnt <= '0; end
        ST_LOAD:
          if (wait_end) begin state <= ST_SETUP; wcnt <= '0; end
          else wcnt <= wcnt + 1'b1;
        ST_SETUP:
          if (wait_end) begin state <= ST_SEND; ch <= '0; end
          else wcnt <= wcnt + 1'b1;
        ST_SEND: state <= ST_WAIT;
        ST_WAIT:
          if (shift_done) begin
            if (ch == 2'd3) state <= ST_CLOSE;
            else begin ch <= ch + 1'b1; state <= ST_SEND; end
          end
        ST_CLOSE: begin ptr <= ptr + 1'b1; state <= ST_IDLE; end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  ldac_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ldac_n_o |-> dac_cs_n_o)
    else $error("ldac_cs_chk");

  // R11
  cs_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n_o |-> dac_fs_o)
    else $error("cs_fs_chk");

endmodule

// File: tb/quad_wave_seq_tb_top.sv
module quad_wave_seq_tb_top;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] period_i = 16'd99;
  logic [3:0]  prescale_i = 4'd3;
  logic sclk, din, fs, cs_n, ldac_n, overrun;

  always #5 clk = ~clk;

  quad_wave_seq #(.SCLK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .prescale_i(prescale_i),
    .dac_sclk_o(sclk), .dac_din_o(din), .dac_fs_o(fs), .dac_cs_n_o(cs_n),
    .dac_ldac_n_o(ldac_n), .overrun_o(overrun));

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  int exp_period = 400;
  int seq_done = 0;
  int ovr_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ref_sample(input int k);
    logic [11:0] qt [0:8] = '{12'h800, 12'h97C, 12'hAE9, 12'hC3A, 12'hD61,
                              12'hE53, 12'hF07, 12'hF76, 12'hF9C};
    int q, j;
    logic [11:0] v;
    q = k % 16;
    j = (q <= 8) ? q : 16 - q;
    v = qt[j];
    return (k % 32 < 16) ? v : 12'(4096 - int'(v));
  endfunction

  // driver: expected frames for n sequences starting at pointer 0 (R6, R7)
  task automatic push_seqs(input int n);
    int offs [4] = '{0, 16, 8, 24};
    for (int s = 0; s < n; s++)
      for (int c = 0; c < 4; c++)
        exp_q.push_back({2'(c), 2'b01, ref_sample((s + offs[c]) % 32)});
  endtask

  // monitor: DAC model and timing checks
  logic p_sclk = 1, p_fs = 1, p_cs = 1, p_ldac = 1;
  logic [15:0] shreg = '0;
  int nbits = 0, frames = 0, fs_hi = 0, ldac_lo = 0, cyc = 0, last_fall = -1;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_sclk = 1; p_fs = 1; p_cs = 1; p_ldac = 1;
      nbits = 0; frames = 0; fs_hi = 0; ldac_lo = 0; last_fall = -1;
    end else begin
      if (overrun) ovr_cnt++;
      if (p_sclk && !sclk && !fs && !cs_n) begin
        shreg = {shreg[14:0], din};
        nbits++;
      end
      if (!p_fs && fs) begin
        chk(nbits == 16, "R9 bits before fs rise", nbits, 16);
        chk(sclk == 1'b1, "R9 sclk high at fs rise", int'(sclk), 1);
        if (exp_q.size() == 0) chk(0, "R5 unexpected frame", int'(shreg), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(shreg == e, "R5/R6 frame content", int'(shreg), int'(e));
        end
        frames++; nbits = 0; fs_hi = 0;
      end
      if (fs) fs_hi++;
      if (p_fs && !fs && frames > 0)
        chk(fs_hi >= 2 * HALF, "R9 fs high gap", fs_hi, 2 * HALF);
      if (!p_cs && cs_n) begin
        chk(frames == 4, "R4 frames per cs window", frames, 4);
        frames = 0;
        seq_done++;
      end
      if (!ldac_n) begin
        ldac_lo++;
        if (ldac_lo == 1) chk(cs_n, "R3 cs high during ldac", int'(cs_n), 1);
      end
      if (p_ldac && !ldac_n) begin
        if (last_fall >= 0)
          chk(cyc - last_fall == exp_period, "R2 tick spacing", cyc - last_fall, exp_period);
        last_fall = cyc;
      end
      if (!p_ldac && ldac_n) begin
        chk(ldac_lo == HALF, "R3 ldac width", ldac_lo, HALF);
        ldac_lo = 0;
      end
      p_sclk = sclk; p_fs = fs; p_cs = cs_n; p_ldac = ldac_n;
    end
  end

  task automatic check_reset_state();
    chk(cs_n && fs && ldac_n && sclk && !overrun, "R1 reset outputs",
        int'({cs_n, fs, ldac_n, sclk, overrun}), 5'b11110);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", seq_done, 50);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    // phase 1: long period, pointer wraps (R2..R9, R11)
    repeat (4) @(negedge clk);
    check_reset_state();
    push_seqs(40);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check_reset_state();
    wait (seq_done == 40);
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 all frames seen", exp_q.size(), 0);
    chk(ovr_cnt == 0, "R10 no overrun at long period", ovr_cnt, 0);
    // phase 2: period shorter than a sequence (R10)
    rst_n = 1'b0;
    period_i = 16'd49;
    repeat (4) @(negedge clk);
    check_reset_state();
    ovr_cnt = 0;
    exp_period = 400;
    push_seqs(10);
    rst_n = 1'b1;
    wait (seq_done == 50);
    @(negedge clk);
    chk(exp_q.size() == 0, "R10 pointer not advanced by skipped ticks", exp_q.size(), 0);
    chk(ovr_cnt >= 9, "R10 overrun pulses", ovr_cnt, 9);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule